// File: doc/BRIEF.md
# Result Buffer with Threshold Interrupt Counter

This block stores conversion results in a small circular memory and keeps a signed threshold counter that tells software when enough results have gathered. The converter side offers one result per cycle. The host side takes results out in arrival order (queue pop), or looks at any slot by its physical index without removing it. Before a run, software loads the counter with the number of results it wants to wait for. Each stored result counts the value down and each queue pop counts it back up. When a count-down lands on zero or below, a sticky flag is raised, and the interrupt output follows that flag gated by an enable bit.

The memory can be full when a new result arrives. The block then applies one of two policies, chosen by an input pin. In keep mode the new result is dropped and the counter does not move. In overwrite mode the oldest entry is replaced and the counter still counts down. Both cases set a sticky overrun status bit. Software reaches the counter and the status bits through a 32-bit register port with a write strobe and a combinational read mux.

Top module: `rbuf_thresh_irq`

## Requirements
- R1: After reset the counter reads 0, the enable, flag and overrun bits read 0, `irq` is 0 and the memory is empty.
- R2: A read of address 0 returns the 9-bit counter in bits 8:0, copies of bit 8 in bits 15:9 and zeros in bits 31:16. A write to address 0 loads only bits 8:0 of the write data.
- R3: A result that is stored while no queue pop happens in the same cycle decrements the counter by one (two's complement, 9 bits).
- R4: A queue pop (`fifo_rd` with the memory not empty) returns the oldest stored result on `rd_data` in the same cycle, removes it, and increments the counter by one. `fifo_rd` has priority over `dir_rd`.
- R5: A direct read (`dir_rd` without `fifo_rd`) returns slot `dir_idx` of the memory and leaves the counter, the fill level and the read order unchanged. `rd_data` is zero when neither read is requested.
- R6: When a result is stored and a queue pop happens in the same cycle, the counter keeps its value. A pop from a full memory makes room, so the write is stored and is not an overrun.
- R7: A result that arrives while the memory holds 16 entries, with no pop in that cycle and `ovwr_en` low, is discarded. The counter and the fill level do not change, and overrun (address 1 bit 2) is set.
- R8: Under the same conditions with `ovwr_en` high, the oldest entry is replaced by the new result, the counter decrements, the fill level stays at 16 and overrun is set.
- R9: A queue pop of an empty memory returns 0 on `rd_data` and changes neither the counter nor the pointers.
- R10: The flag (address 1 bit 1) is set when a decrement produces a value of zero or less. It stays set until software writes 1 to bit 1 of address 1, and a set in the same cycle wins over the clear. Overrun is cleared the same way through bit 2. Bit 0 of address 1 is the read/write interrupt enable, and `irq` equals flag AND enable.
- R11: A software write to address 0 takes priority over a store or pop in the same cycle: the counter takes the written value, while the memory still performs the store or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | A conversion result is offered this cycle |
| res_data | input | 12 | Conversion result |
| ovwr_en | input | 1 | 1: replace the oldest entry when full; 0: drop the new result |
| fifo_rd | input | 1 | Queue pop request |
| dir_rd | input | 1 | Direct slot read request |
| dir_idx | input | 4 | Physical slot index for a direct read |
| rd_data | output | 12 | Read result, combinational |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 counter, 1 control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Threshold interrupt |

## Verification
The properties assume that software never writes the counter and expects an event-driven change in the same cycle. They are therefore conditioned on there being no address-0 write, and a separate property covers the load itself. They also assume that a direct read never coincides with a pop on purpose, since the pop wins. The stimulus still mixes both on purpose, and the bench model gives the queue read priority just as the requirement does. The bench drives inputs only between clock edges. It sweeps fill levels from empty to overrun under both overflow policies and reloads the counter with positive, zero and negative values, so each property precondition is reached many times.

// File: rtl/rbuf_pkg.sv
`timescale 1ns/1ps
package rbuf_pkg;

    typedef enum logic [1:0] {
        SEL_THR = 2'd0,
        SEL_CSR = 2'd1
    } rsel_e;

    localparam int CSR_EN   = 0;
    localparam int CSR_FLAG = 1;
    localparam int CSR_OVR  = 2;

    typedef struct packed {
        logic wr_take;   // result stored into a free (or freed) slot
        logic wr_evict;  // result stored over the oldest entry
        logic wr_drop;   // result discarded, memory full
        logic pop;       // oldest entry removed by a queue read
    } buf_evt_t;

    function automatic logic evt_dec(buf_evt_t e);
        return e.wr_take | e.wr_evict;
    endfunction

    function automatic logic evt_ovr(buf_evt_t e);
        return e.wr_evict | e.wr_drop;
    endfunction

endpackage

// File: rtl/rbuf_store.sv
`timescale 1ns/1ps
module rbuf_store
    import rbuf_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          ovwr_en,
    input  logic          fifo_rd,
    input  logic          dir_rd,
    input  logic [AW-1:0] dir_idx,
    output logic [DW-1:0] rd_data,
    output buf_evt_t      evt,
    output logic [AW:0]   fill
);
    localparam logic [AW:0] FULL_LVL = DEPTH[AW:0];

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [AW:0]   fill_q;
    logic          full, empty;

    assign full  = (fill_q == FULL_LVL);
    assign empty = (fill_q == '0);
    assign fill  = fill_q;

    always_comb begin
        evt          = '0;
        evt.pop      = fifo_rd && !empty;
        evt.wr_take  = res_valid && (!full || evt.pop);
        evt.wr_evict = res_valid && full && !evt.pop && ovwr_en;
        evt.wr_drop  = res_valid && full && !evt.pop && !ovwr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (evt_dec(evt)) begin
            mem_q[wptr_q] <= res_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (evt_dec(evt))            wptr_q <= wptr_q + 1'b1;
            if (evt.pop || evt.wr_evict) rptr_q <= rptr_q + 1'b1;
            if (evt.wr_take && !evt.pop)      fill_q <= fill_q + 1'b1;
            else if (evt.pop && !evt.wr_take) fill_q <= fill_q - 1'b1;
        end
    end

    always_comb begin
        if (fifo_rd)     rd_data = empty ? '0 : mem_q[rptr_q];
        else if (dir_rd) rd_data = mem_q[dir_idx];
        else             rd_data = '0;
    end

endmodule

// File: rtl/rbuf_thresh.sv
`timescale 1ns/1ps
module rbuf_thresh
    import rbuf_pkg::*;
#(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  buf_evt_t      evt,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    input  logic          clr_flag,
    output logic [TW-1:0] thr,
    output logic          flag
);
    logic [TW-1:0] thr_q, thr_dn;
    logic          flag_q, dn_only, up_only, hit;

    assign dn_only = evt_dec(evt) && !evt.pop;
    assign up_only = evt.pop && !evt_dec(evt);
    assign thr_dn  = thr_q - 1'b1;
    assign hit     = !ld && dn_only && (thr_dn[TW-1] || (thr_dn == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ld)           thr_q <= ld_val;
            else if (dn_only) thr_q <= thr_dn;
            else if (up_only) thr_q <= thr_q + 1'b1;

            if (hit)           flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
        end
    end

    assign thr  = thr_q;
    assign flag = flag_q;

endmodule

// File: rtl/rbuf_regs.sv
`timescale 1ns/1ps
module rbuf_regs
    import rbuf_pkg::*;
#(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic [TW-1:0] thr,
    input  logic          flag,
    input  logic          ovr_evt,
    output logic [31:0]   reg_rdata,
    output logic          ld,
    output logic [TW-1:0] ld_val,
    output logic          clr_flag,
    output logic          en,
    output logic          ovr
);
    localparam int EXT = 16 - TW;

    logic csr_we, en_q, ovr_q;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[31:TW];

    assign ld       = reg_we && (reg_addr == SEL_THR);
    assign ld_val   = reg_wdata[TW-1:0];
    assign csr_we   = reg_we && (reg_addr == SEL_CSR);
    assign clr_flag = csr_we && reg_wdata[CSR_FLAG];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (csr_we) en_q <= reg_wdata[CSR_EN];
            if (ovr_evt)                            ovr_q <= 1'b1;
            else if (csr_we && reg_wdata[CSR_OVR])  ovr_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            SEL_THR: reg_rdata = {16'h0000, {EXT{thr[TW-1]}}, thr};
            SEL_CSR: reg_rdata = {29'd0, ovr_q, flag, en_q};
            default: reg_rdata = '0;
        endcase
    end

    assign en  = en_q;
    assign ovr = ovr_q;

endmodule

// File: rtl/rbuf_thresh_irq.sv
`timescale 1ns/1ps
module rbuf_thresh_irq
    import rbuf_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    parameter int TW    = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          ovwr_en,
    input  logic          fifo_rd,
    input  logic          dir_rd,
    input  logic [AW-1:0] dir_idx,
    output logic [DW-1:0] rd_data,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq
);
    buf_evt_t      evt;
    logic [AW:0]   fill_w;
    logic [TW-1:0] thr_w, ld_val;
    logic          flag_w, en_w, ovr_w, ld, clr_flag;

    rbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .res_valid(res_valid), .res_data(res_data), .ovwr_en(ovwr_en),
        .fifo_rd(fifo_rd), .dir_rd(dir_rd), .dir_idx(dir_idx),
        .rd_data(rd_data), .evt(evt), .fill(fill_w)
    );

    rbuf_thresh #(.TW(TW)) u_thresh (
        .clk(clk), .rst(rst), .evt(evt),
        .ld(ld), .ld_val(ld_val), .clr_flag(clr_flag),
        .thr(thr_w), .flag(flag_w)
    );

    rbuf_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .thr(thr_w), .flag(flag_w), .ovr_evt(evt_ovr(evt)),
        .reg_rdata(reg_rdata), .ld(ld), .ld_val(ld_val),
        .clr_flag(clr_flag), .en(en_w), .ovr(ovr_w)
    );

    assign irq = flag_w & en_w;

endmodule

// File: rtl/rbuf_chk.sv
`timescale 1ns/1ps
module rbuf_chk #(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    parameter int TW    = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          res_valid,
    input logic          ovwr_en,
    input logic          fifo_rd,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic [TW-1:0] wdat_lo,
    input logic          clr_req,
    input logic [DW-1:0] rd_data,
    input logic          irq,
    input logic [TW-1:0] thr,
    input logic          flag,
    input logic          en,
    input logic          ovr,
    input logic [AW:0]   fill
);
    localparam logic [AW:0] FULL_LVL = DEPTH[AW:0];

    logic sw_ld, pop, take;
    assign sw_ld = reg_we && (reg_addr == 2'd0);
    assign pop   = fifo_rd && (fill != '0);
    assign take  = res_valid && ((fill != FULL_LVL) || pop || ovwr_en);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (thr == '0 && !flag && !en && !ovr && fill == '0 && !irq));

    assert_store_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !pop && !sw_ld) |=> (thr == $past(thr) - 1'b1));

    assert_pop_inc_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && !take && !sw_ld) |=> (thr == $past(thr) + 1'b1));

    assert_cancel_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && take && !sw_ld) |=> $stable(thr));

    assert_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && fill == FULL_LVL && !ovwr_en && !fifo_rd && !sw_ld)
        |=> ($stable(thr) && $stable(fill) && ovr));

    assert_fill_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL_LVL);

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd && fill == '0) |-> (rd_data == '0));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag && !(reg_we && reg_addr == 2'd1 && clr_req)) |=> flag);

    assert_sw_load_R11: assert property (@(posedge clk) disable iff (rst)
        sw_ld |=> (thr == $past(wdat_lo)));

endmodule

bind rbuf_thresh_irq rbuf_chk #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) u_rbuf_chk (
    .clk(clk), .rst(rst), .res_valid(res_valid), .ovwr_en(ovwr_en),
    .fifo_rd(fifo_rd), .reg_we(reg_we), .reg_addr(reg_addr),
    .wdat_lo(reg_wdata[TW-1:0]), .clr_req(reg_wdata[1]),
    .rd_data(rd_data), .irq(irq), .thr(thr_w), .flag(flag_w),
    .en(en_w), .ovr(ovr_w), .fill(fill_w)
);

// File: tb/test_rbuf_thresh_irq.sv
`timescale 1ns/1ps
module test_rbuf_thresh_irq;
    localparam int DW = 12, DEPTH = 16, AW = 4, TW = 9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          res_valid = 0, ovwr_en = 0, fifo_rd = 0, dir_rd = 0, reg_we = 0;
    logic [DW-1:0] res_data = '0;
    logic [AW-1:0] dir_idx = '0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [DW-1:0] rd_data;
    logic [31:0]   reg_rdata;
    logic          irq;

    rbuf_thresh_irq i_rbuf_thresh_irq (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .ovwr_en(ovwr_en), .fifo_rd(fifo_rd), .dir_rd(dir_rd), .dir_idx(dir_idx),
        .rd_data(rd_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [DW-1:0]        m_mem [DEPTH];
    int                   m_w = 0, m_r = 0, m_fill = 0;
    logic signed [TW-1:0] m_thr = '0;
    logic                 m_flag = 0, m_en = 0, m_ovr = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] thr_word(input logic signed [TW-1:0] t);
        return {16'h0000, {(16-TW){t[TW-1]}}, t};
    endfunction

    task automatic check_regs(input string tag);
        reg_addr = 2'd0; #1;
        chk({tag, " counter"}, reg_rdata, thr_word(m_thr));
        reg_addr = 2'd1; #1;
        chk("R10 status", reg_rdata, {29'd0, m_ovr, m_flag, m_en});
        chk("R10 irq", {31'd0, irq}, {31'd0, m_flag & m_en});
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic wv, input logic [DW-1:0] wd, input logic ow,
                        input logic rf, input logic rd, input logic [AW-1:0] idx,
                        input logic we, input logic [1:0] ad, input logic [31:0] wdat);
        logic pop, take, evict, drop, ld, dec;
        logic [DW-1:0] exp_rd;
        logic signed [TW-1:0] nt;
        string tag;
        res_valid = wv; res_data = wd; ovwr_en = ow; fifo_rd = rf; dir_rd = rd;
        dir_idx = idx; reg_we = we; reg_addr = ad; reg_wdata = wdat;
        #1;
        pop   = rf && (m_fill > 0);
        take  = wv && ((m_fill < DEPTH) || pop);
        evict = wv && !take && ow;
        drop  = wv && !take && !ow;
        ld    = we && (ad == 2'd0);
        dec   = take || evict;
        if (rf)      exp_rd = pop ? m_mem[m_r] : '0;
        else if (rd) exp_rd = m_mem[idx];
        else         exp_rd = '0;
        chk(rf ? (pop ? "R4 pop data" : "R9 empty pop") : "R5 direct data",
            {20'd0, rd_data}, {20'd0, exp_rd});
        if (ld)                tag = "R11";
        else if (take && pop)  tag = "R6";
        else if (drop)         tag = "R7";
        else if (evict)        tag = "R8";
        else if (take)         tag = "R3";
        else if (pop)          tag = "R4";
        else if (rf)           tag = "R9";
        else                   tag = "R5";
        @(posedge clk); #1;
        res_valid = 0; fifo_rd = 0; dir_rd = 0; reg_we = 0;
        // model update
        if (dec) begin m_mem[m_w] = wd; m_w = (m_w + 1) % DEPTH; end
        if (pop || evict) m_r = (m_r + 1) % DEPTH;
        if (take && !pop) m_fill++;
        else if (pop && !take) m_fill--;
        if (we && ad == 2'd1) begin
            m_en = wdat[0];
            if (wdat[1]) m_flag = 0;
            if (wdat[2]) m_ovr = 0;
        end
        if (evict || drop) m_ovr = 1;
        if (ld) m_thr = wdat[TW-1:0];
        else if (dec && !pop) begin
            nt = m_thr - 1;
            m_thr = nt;
            if (nt <= 0) m_flag = 1;
        end else if (pop && !dec) m_thr = m_thr + 1;
        check_regs(tag);
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        reg_addr = 2'd0; #1; chk("R1 counter", reg_rdata, 32'h0);
        reg_addr = 2'd1; #1; chk("R1 status", reg_rdata, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        fifo_rd = 1; #1; chk("R1 R9 empty", {20'd0, rd_data}, 32'h0); fifo_rd = 0;
        @(negedge clk);
        // R2 register format
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FE05);
        reg_addr = 2'd0; #1; chk("R2 upper ignored", reg_rdata, 32'h0000_0005);
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_01FD);
        reg_addr = 2'd0; #1; chk("R2 sign ext", reg_rdata, 32'h0000_FFFD);
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0100);
        reg_addr = 2'd0; #1; chk("R2 most negative", reg_rdata, 32'h0000_FF00);
        @(negedge clk);
        // enable, clear and load 4
        step(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h7);
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'd4);
        // sweep over fill levels, policies and read kinds
        for (int i = 0; i < 1200; i++) begin
            int  ph;
            logic wv, rf, rd, ow, we;
            logic [1:0]  ad;
            logic [31:0] wdat;
            ph = i / 100;
            ow = ph[2];
            wv = (ph % 2 == 0) ? (i % 5 != 0) : (i % 5 == 0);
            rf = (ph % 2 == 0) ? (i % 4 == 0 && ph < 4) : (i % 5 != 0);
            rd = (i % 7 == 0);
            we = 0; ad = 2'd0; wdat = '0;
            if (i % 64 == 0) begin
                we = 1; ad = 2'd0; wdat = 32'(i / 64) * 3 - 6;
            end else if (i % 64 == 32) begin
                we = 1; ad = 2'd1; wdat = (i % 128 == 96) ? 32'h6 : 32'h7;
            end
            step(wv, DW'(i * 37 + 5), ow, rf, rd, AW'(i * 5), we, ad, wdat);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule